// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block decides, cycle by cycle, whether the decoded instruction at the head of an in-order issue stage may be sent to its functional unit. It tracks two bit vectors: a busy flag for each functional unit class (integer, add, multiply, divide) and a write-pending flag for each architectural register. A request names a unit class, a destination register and up to two source registers, each source with its own enable. The request is granted only when its unit is idle, no enabled source is awaiting a result (read-after-write) and the destination is not already awaiting a result (write-after-write).

A grant marks the unit busy and the destination pending from the next cycle on. A write-back event names the unit that finished and the register it wrote, and clears both flags. A write-back is visible to the grant decision in the same cycle it arrives. The issue stage holds the same request until it is granted, so one instruction at most leaves per cycle, in program order. Because issue is in order, write-after-read hazards cannot occur and are not checked.

Top module: `issue_hazard_sb`

## Requirements
- R1: After a synchronous active-low reset, every unit busy flag and every register pending flag is 0.
- R2: A request whose unit class (0 integer, 1 add, 2 multiply, 3 divide) has its busy flag set raises `stall_unit` and is not granted.
- R3: A request with an enabled source whose register has its pending flag set raises `stall_raw` and is not granted.
- R4: A request whose destination register has its pending flag set raises `stall_waw` and is not granted.
- R5: A source whose enable is 0 never causes `stall_raw`, whatever the pending state of the register it names.
- R6: No write-after-read check exists. A request whose destination equals one of its own enabled sources is granted when that register is not pending and the unit is idle.
- R7: A grant sets the busy flag of the request's unit and the pending flag of its destination, and both are visible on the vector outputs in the next cycle.
- R8: A write-back clears the busy flag of its unit and the pending flag of its register in the next cycle. If a grant in the same cycle sets the same flag, the flag stays set.
- R9: A write-back in the same cycle as a request counts as already done. A stall caused only by that unit or register is lifted in that cycle.
- R10: `issue` is high exactly when `req_valid` is high and none of the three stall flags is raised. It is never high without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A decoded instruction is presented |
| req_unit | input | UNIT_W | Functional unit class: 0 integer, 1 add, 2 multiply, 3 divide |
| req_dst | input | REG_W | Destination register |
| req_src_a | input | REG_W | First source register |
| req_src_a_en | input | 1 | First source is read |
| req_src_b | input | REG_W | Second source register |
| req_src_b_en | input | 1 | Second source is read |
| wb_valid | input | 1 | A write-back completes this cycle |
| wb_unit | input | UNIT_W | Unit that finished |
| wb_reg | input | REG_W | Register written back |
| issue | output | 1 | Request is granted this cycle |
| stall_unit | output | 1 | Unit busy hazard |
| stall_raw | output | 1 | Read-after-write hazard |
| stall_waw | output | 1 | Write-after-write hazard |
| busy_vec | output | NUM_UNITS | Unit busy flags |
| pend_vec | output | NUM_REGS | Register pending flags |

## Verification
Directed cases cover each hazard on its own: a busy unit, a pending first or second source, a pending destination, a pending register named by a disabled source, and a destination that equals a source. Together these separate the three stall flags from one another and from the source enables. A same-cycle write-back against each hazard kind shows that the bypass lifts exactly the stall it should. A write-back that meets a grant to the same register or unit shows that the set takes priority over the clear. Random traffic on a small register window produces frequent overlaps. In that traffic each grant and each stall flag is compared with a bench model, and both vectors are compared after every edge.

// File: rtl/sb_pkg.sv
// Shared definitions for the issue scoreboard.
// Assumes the standard four unit classes; the encoding below is fixed.
package sb_pkg;
    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_ADD = 2'd1,
        UNIT_MUL = 2'd2,
        UNIT_DIV = 2'd3
    } unit_cls_e;
endpackage

// File: rtl/sb_bit_track.sv
// Vector of N set/clear flags, used for both unit busy and register
// pending state. Set has priority over clear on the same index.
// Also provides a bypass view: the stored state with this cycle's clear
// already applied. Assumes set_idx and clr_idx are below N when enabled.
module sb_bit_track #(
    parameter int N  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  state_q,
    output logic [N-1:0]  view
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic hit_set, hit_clr;
        assign hit_set = set_en && (set_idx == IW'(i));
        assign hit_clr = clr_en && (clr_idx == IW'(i));

        // Per-flag update: reset, then set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       state_q[i] <= 1'b0;
            else if (hit_set) state_q[i] <= 1'b1;
            else if (hit_clr) state_q[i] <= 1'b0;
        end

        // Bypass view: a clear arriving now already counts.
        assign view[i] = state_q[i] && !hit_clr;
    end

    a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> state_q[$past(set_idx)]);

    a_r8_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !state_q[$past(clr_idx)]);
endmodule

// File: rtl/sb_hazard_eval.sv
// Combinational grant decision from the bypassed busy and pending views.
// Checks unit availability, RAW on enabled sources and WAW on the
// destination; write-after-read is not checked since issue is in order.
module sb_hazard_eval #(
    parameter int NUM_UNITS = 4,
    parameter int NUM_REGS  = 32,
    parameter int UNIT_W    = 2,
    parameter int REG_W     = 5
) (
    input  logic                 req_valid,
    input  logic [UNIT_W-1:0]    req_unit,
    input  logic [REG_W-1:0]     req_dst,
    input  logic [REG_W-1:0]     req_src_a,
    input  logic                 req_src_a_en,
    input  logic [REG_W-1:0]     req_src_b,
    input  logic                 req_src_b_en,
    input  logic [NUM_UNITS-1:0] busy_view,
    input  logic [NUM_REGS-1:0]  pend_view,
    output logic                 hz_unit,
    output logic                 hz_raw,
    output logic                 hz_waw,
    output logic                 grant
);
    // Hazard flags are qualified by req_valid so idle cycles show none.
    always_comb begin
        hz_unit = req_valid && busy_view[req_unit];
        hz_raw  = req_valid && ((req_src_a_en && pend_view[req_src_a]) ||
                                (req_src_b_en && pend_view[req_src_b]));
        hz_waw  = req_valid && pend_view[req_dst];
        grant   = req_valid && !hz_unit && !hz_raw && !hz_waw;
    end
endmodule

// File: rtl/issue_hazard_sb.sv
// Issue-stage hazard scoreboard for an in-order pipeline with several
// functional units. Grants at most one request per cycle; the issue stage
// must hold a stalled request unchanged so program order is kept.
// Assumes a write-back names a unit and register that were granted earlier.
module issue_hazard_sb #(
    parameter int NUM_UNITS = 4,
    parameter int NUM_REGS  = 32,
    parameter int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    parameter int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [UNIT_W-1:0]    req_unit,
    input  logic [REG_W-1:0]     req_dst,
    input  logic [REG_W-1:0]     req_src_a,
    input  logic                 req_src_a_en,
    input  logic [REG_W-1:0]     req_src_b,
    input  logic                 req_src_b_en,
    input  logic                 wb_valid,
    input  logic [UNIT_W-1:0]    wb_unit,
    input  logic [REG_W-1:0]     wb_reg,
    output logic                 issue,
    output logic                 stall_unit,
    output logic                 stall_raw,
    output logic                 stall_waw,
    output logic [NUM_UNITS-1:0] busy_vec,
    output logic [NUM_REGS-1:0]  pend_vec
);
    logic [NUM_UNITS-1:0] busy_view;
    logic [NUM_REGS-1:0]  pend_view;

    // Unit busy flags: set by a grant, cleared by the unit's write-back.
    sb_bit_track #(.N(NUM_UNITS), .IW(UNIT_W)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .set_en(issue), .set_idx(req_unit),
        .clr_en(wb_valid), .clr_idx(wb_unit),
        .state_q(busy_vec), .view(busy_view)
    );

    // Register pending flags: set by a grant, cleared by write-back.
    sb_bit_track #(.N(NUM_REGS), .IW(REG_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(issue), .set_idx(req_dst),
        .clr_en(wb_valid), .clr_idx(wb_reg),
        .state_q(pend_vec), .view(pend_view)
    );

    // Grant decision against the bypassed state.
    sb_hazard_eval #(
        .NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS),
        .UNIT_W(UNIT_W), .REG_W(REG_W)
    ) u_eval (
        .req_valid(req_valid), .req_unit(req_unit), .req_dst(req_dst),
        .req_src_a(req_src_a), .req_src_a_en(req_src_a_en),
        .req_src_b(req_src_b), .req_src_b_en(req_src_b_en),
        .busy_view(busy_view), .pend_view(pend_view),
        .hz_unit(stall_unit), .hz_raw(stall_raw), .hz_waw(stall_waw),
        .grant(issue)
    );

    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (busy_vec == '0 && pend_vec == '0));

    a_r10_issue_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> req_valid);

    a_r2_issue_unit_free: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!busy_vec[req_unit] || (wb_valid && wb_unit == req_unit)));

    a_r4_issue_dst_free: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!pend_vec[req_dst] || (wb_valid && wb_reg == req_dst)));

    a_r7_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> busy_vec[$past(req_unit)]);
endmodule

// File: tb/sim_issue_hazard_sb.sv
module sim_issue_hazard_sb;
    localparam int NU = 4;
    localparam int NR = 32;
    localparam int UW = 2;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_src_a_en = 1'b0, req_src_b_en = 1'b0;
    logic [UW-1:0] req_unit = '0, wb_unit = '0;
    logic [RW-1:0] req_dst = '0, req_src_a = '0, req_src_b = '0, wb_reg = '0;
    logic wb_valid = 1'b0;
    logic issue, stall_unit, stall_raw, stall_waw;
    logic [NU-1:0] busy_vec;
    logic [NR-1:0] pend_vec;

    logic [NU-1:0] m_busy = '0;
    logic [NR-1:0] m_pend = '0;
    int n_run = 0, n_fail = 0;
    int unsigned seed_val;

    always #5 clk = ~clk;

    issue_hazard_sb #(.NUM_UNITS(NU), .NUM_REGS(NR)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_unit(req_unit), .req_dst(req_dst),
        .req_src_a(req_src_a), .req_src_a_en(req_src_a_en),
        .req_src_b(req_src_b), .req_src_b_en(req_src_b_en),
        .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg),
        .issue(issue), .stall_unit(stall_unit), .stall_raw(stall_raw),
        .stall_waw(stall_waw), .busy_vec(busy_vec), .pend_vec(pend_vec)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench model of the decision, with write-back bypass.
    function automatic logic [3:0] model_flags();
        logic [NU-1:0] bv;
        logic [NR-1:0] pv;
        logic hu, hr, hw;
        bv = m_busy; pv = m_pend;
        if (wb_valid) begin
            bv[wb_unit] = 1'b0;
            pv[wb_reg]  = 1'b0;
        end
        hu = req_valid && bv[req_unit];
        hr = req_valid && ((req_src_a_en && pv[req_src_a]) || (req_src_b_en && pv[req_src_b]));
        hw = req_valid && pv[req_dst];
        return {req_valid && !hu && !hr && !hw, hu, hr, hw};
    endfunction

    // One cycle: inputs set at the falling edge, decision checked before
    // the rising edge, vectors checked after it.
    task automatic step(input string tag);
        logic [3:0] e;
        #1;
        e = model_flags();
        chk(issue == e[3], {tag, " R10 issue"}, issue, e[3]);
        chk(stall_unit == e[2], {tag, " R2 stall_unit"}, stall_unit, e[2]);
        chk(stall_raw == e[1], {tag, " R3 stall_raw"}, stall_raw, e[1]);
        chk(stall_waw == e[0], {tag, " R4 stall_waw"}, stall_waw, e[0]);
        @(posedge clk);
        if (wb_valid) begin
            m_busy[wb_unit] = 1'b0;
            m_pend[wb_reg]  = 1'b0;
        end
        if (e[3]) begin
            m_busy[req_unit] = 1'b1;
            m_pend[req_dst]  = 1'b1;
        end
        #1;
        chk(busy_vec == m_busy, {tag, " R7/R8 busy_vec"}, 64'(busy_vec), 64'(m_busy));
        chk(pend_vec == m_pend, {tag, " R7/R8 pend_vec"}, 64'(pend_vec), 64'(m_pend));
        @(negedge clk);
        req_valid = 1'b0; wb_valid = 1'b0;
    endtask

    task automatic req(input int u, input int d, input int a, input bit ae, input int b, input bit be);
        req_valid = 1'b1; req_unit = UW'(u); req_dst = RW'(d);
        req_src_a = RW'(a); req_src_a_en = ae; req_src_b = RW'(b); req_src_b_en = be;
    endtask

    task automatic wb(input int u, input int r);
        wb_valid = 1'b1; wb_unit = UW'(u); wb_reg = RW'(r);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        seed_val = 32'd20251;
        void'($urandom(seed_val));
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy_vec == '0, "R1 busy after reset", 64'(busy_vec), 0);
        chk(pend_vec == '0, "R1 pend after reset", 64'(pend_vec), 0);

        // Grant multiply writing r5 (R7)
        req(2, 5, 1, 1, 2, 1); step("R7 first grant");
        chk(busy_vec[2] && pend_vec[5], "R7 flags set", {busy_vec, pend_vec[5]}, 5'b01001);
        // R2: multiply busy
        req(2, 6, 1, 0, 2, 0); step("R2 unit busy");
        // R3: RAW on source a, then on source b
        req(1, 7, 5, 1, 0, 0); step("R3 raw src a");
        req(1, 7, 0, 0, 5, 1); step("R3 raw src b");
        // R5: disabled source naming r5
        req(1, 7, 5, 0, 5, 0);
        #1; chk(issue == 1'b1 && !stall_raw, "R5 disabled sources", {issue, stall_raw}, 2'b10);
        step("R5 grant");
        // R4: WAW on r5
        req(0, 5, 0, 0, 0, 0); step("R4 waw");
        // R9: same-cycle write-back lifts the WAW and the unit busy
        req(2, 5, 0, 0, 0, 0); wb(2, 5);
        #1; chk(issue == 1'b1, "R9 bypass grant", issue, 1);
        step("R9 bypass");
        // R8: set wins over clear on same reg and unit
        chk(pend_vec[5] && busy_vec[2], "R8 set over clear", {busy_vec[2], pend_vec[5]}, 2'b11);
        // R8: plain clear
        wb(2, 5); step("R8 clear");
        chk(!pend_vec[5] && !busy_vec[2], "R8 cleared", {busy_vec[2], pend_vec[5]}, 0);
        // R6: destination equals source, no WAR check
        req(3, 9, 9, 1, 9, 1);
        #1; chk(issue == 1'b1, "R6 dst equals src", issue, 1);
        step("R6 grant");
        // R10: no grant without valid
        req_valid = 1'b0; #1;
        chk(issue == 1'b0, "R10 idle", issue, 0);
        step("R10 idle");
        // Drain
        wb(1, 7); step("drain1");
        wb(3, 9); step("drain2");

        // Random traffic on a small register window
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 4 != 0)
                req($urandom % 4, $urandom % 8, $urandom % 8, 1'($urandom), $urandom % 8, 1'($urandom));
            if ($urandom % 3 == 0) wb($urandom % 4, $urandom % 8);
            step("rand R3 R4 R10");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule